// File: doc/BRIEF.md
# Montgomery Exponentiation Sequencer

This block drives a left-to-right square-and-multiply modular exponentiation, C = P^E mod M, on an external Montgomery multiplier that returns A·B·2^(-17d) mod M. It does no arithmetic itself. For each call it chooses two operand handles and a destination register, pulses a start strobe, and waits for the multiplier's completion strobe. When the whole chain has finished it raises a one-cycle done pulse.

The chain has three phases. First, two calls bring values into the Montgomery domain by multiplying with the precomputed constant 2^(2·17d) mod M: one call on the constant 1 builds the running result, and one call on the message builds the base. Next, the exponent is scanned from its top bit down to bit zero. Every bit costs one squaring, and every set bit costs one more multiplication by the base. Last, one multiplication by the constant 1 takes the result out of the Montgomery domain. The exponent and its bit length are captured when a run is accepted. The modulus must be odd, and every value handed to the multiplier is already reduced below it.

Top module: `modexp_sequencer`

## Requirements
- R1: While reset is active and right after it, busy, done and mul_start are all 0.
- R2: The operand codes are C=0, P=1, ONE=2, R2=3, and the destination code is 0 for C and 1 for P. The first call of a run is (R2, ONE) into C, starts in the same cycle busy rises, and is followed by (R2, P) into P. Only this second call ever writes P.
- R3: The exponent is scanned from bit exp_len−1 down to bit 0. Each bit issues (C, C) into C, and a set bit then also issues (C, P) into C. The final result equals P^E mod M.
- R4: The last call of a run is (C, ONE) into C. done is high for exactly one cycle, in the cycle after that call's mul_done, and busy is low in that cycle.
- R5: A run makes exactly 3 + exp_len + popcount(E) calls, where E is the low exp_len bits of exp_bits.
- R6: At most one call is outstanding at a time. mul_start is never raised between a mul_start and its mul_done.
- R7: mul_start is high for one cycle per call.
- R8: start is ignored while busy is high. This holds even when start is held high through the final mul_done. Changes to exp_bits and exp_len after a run has been accepted do not affect that run.
- R9: If exp_len is 0, or E is 0, the run still performs the entry and exit calls and returns 1 mod M.
- R10: A mul_done with no call outstanding is ignored: no done, no busy, no mul_start.
- R11: After the mul_done of any call except the last, the next call's mul_start comes in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new exponentiation (taken only when idle) |
| exp_bits | input | EXP_W | Exponent value, captured at acceptance |
| exp_len | input | $clog2(EXP_W+1) | Number of exponent bits to scan, 0..EXP_W |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| mul_start | output | 1 | Start strobe to the multiplier |
| mul_sel_a | output | 2 | First operand code (C=0, P=1, ONE=2, R2=3) |
| mul_sel_b | output | 2 | Second operand code (C=0, P=1, ONE=2, R2=3) |
| mul_dest | output | 1 | Destination register (0 = C, 1 = P) |
| mul_done | input | 1 | Multiplier completion strobe |

## Verification
Two events can coincide here: the final multiplier completion, and a new start request that arrives while that call is still outstanding. The bench provokes this by holding start high from acceptance until it sees done. The held start is present in the same cycle as the last mul_done, and the bench then checks that no second run begins. A multiplier model in the bench uses varying latency and bit-serial Montgomery arithmetic, so a wrong operand code, destination or step order shows up as a wrong final value or a wrong call count. Both are compared against an independent plain modular power.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [1:0] {
    OPD_C   = 2'd0,
    OPD_P   = 2'd1,
    OPD_ONE = 2'd2,
    OPD_R2  = 2'd3
  } opd_e;

  typedef enum logic [2:0] {
    STP_IDLE,
    STP_ENTER_ONE,
    STP_ENTER_P,
    STP_SQUARE,
    STP_TIMES_P,
    STP_LEAVE
  } step_e;

  // Step that follows a finished multiplier call.
  function automatic step_e next_step(step_e cur, logic bit_set, logic at_lsb, logic len_zero);
    case (cur)
      STP_ENTER_ONE: next_step = STP_ENTER_P;
      STP_ENTER_P:   next_step = len_zero ? STP_LEAVE : STP_SQUARE;
      STP_SQUARE:    next_step = bit_set ? STP_TIMES_P : (at_lsb ? STP_LEAVE : STP_SQUARE);
      STP_TIMES_P:   next_step = at_lsb ? STP_LEAVE : STP_SQUARE;
      default:       next_step = STP_IDLE;
    endcase
  endfunction

  // Index moves down after a bit is finished and more bits remain.
  function automatic logic index_moves(step_e cur, logic bit_set, logic at_lsb);
    index_moves = !at_lsb && ((cur == STP_SQUARE && !bit_set) || cur == STP_TIMES_P);
  endfunction

endpackage

// File: rtl/modexp_bit_scanner.sv
module modexp_bit_scanner #(
  parameter int EXP_W = 32,
  localparam int LEN_W = $clog2(EXP_W + 1),
  localparam int IDX_W = (EXP_W > 1) ? $clog2(EXP_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             arm,
  input  logic             step_down,
  output logic             bit_set,
  output logic             at_lsb,
  output logic             len_zero
);
  logic [EXP_W-1:0] exp_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= '0;
      len_q <= '0;
      idx_q <= '0;
    end else begin
      if (capture) begin
        exp_q <= exp_in;
        len_q <= len_in;
      end
      if (arm)
        idx_q <= IDX_W'(len_q - LEN_W'(1));
      else if (step_down)
        idx_q <= idx_q - IDX_W'(1);
    end
  end

  assign bit_set  = exp_q[idx_q];
  assign at_lsb   = (idx_q == '0);
  assign len_zero = (len_q == '0);
endmodule

// File: rtl/modexp_step_decode.sv
module modexp_step_decode
  import modexp_pkg::*;
(
  input  step_e      step,
  output logic [1:0] sel_a,
  output logic [1:0] sel_b,
  output logic       dest_p
);
  always_comb begin
    sel_a  = OPD_C;
    sel_b  = OPD_C;
    dest_p = 1'b0;
    case (step)
      STP_ENTER_ONE: begin sel_a = OPD_R2; sel_b = OPD_ONE; end
      STP_ENTER_P:   begin sel_a = OPD_R2; sel_b = OPD_P; dest_p = 1'b1; end
      STP_SQUARE:    begin sel_a = OPD_C;  sel_b = OPD_C;   end
      STP_TIMES_P:   begin sel_a = OPD_C;  sel_b = OPD_P;   end
      STP_LEAVE:     begin sel_a = OPD_C;  sel_b = OPD_ONE; end
      default:       ;
    endcase
  end
endmodule

// File: rtl/modexp_sequencer.sv
module modexp_sequencer
  import modexp_pkg::*;
#(
  parameter int EXP_W = 32,
  localparam int LEN_W = $clog2(EXP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EXP_W-1:0] exp_bits,
  input  logic [LEN_W-1:0] exp_len,
  output logic             busy,
  output logic             done,
  output logic             mul_start,
  output logic [1:0]       mul_sel_a,
  output logic [1:0]       mul_sel_b,
  output logic             mul_dest,
  input  logic             mul_done
);
  step_e step_q;
  logic  wait_q;
  logic  done_q;

  // Named internal events
  logic accept;
  logic call_fire;
  logic bit_set, at_lsb, len_zero;
  logic arm_idx, dec_idx;

  assign accept    = start && (step_q == STP_IDLE);
  assign call_fire = mul_done && wait_q;
  assign arm_idx   = call_fire && (step_q == STP_ENTER_P);
  assign dec_idx   = call_fire && index_moves(step_q, bit_set, at_lsb);

  modexp_bit_scanner #(.EXP_W(EXP_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .exp_in   (exp_bits),
    .len_in   (exp_len),
    .arm      (arm_idx),
    .step_down(dec_idx),
    .bit_set  (bit_set),
    .at_lsb   (at_lsb),
    .len_zero (len_zero)
  );

  modexp_step_decode u_dec (
    .step  (step_q),
    .sel_a (mul_sel_a),
    .sel_b (mul_sel_b),
    .dest_p(mul_dest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= STP_IDLE;
      wait_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= call_fire && (step_q == STP_LEAVE);
      if (accept)
        step_q <= STP_ENTER_ONE;
      else if (call_fire)
        step_q <= next_step(step_q, bit_set, at_lsb, len_zero);
      if (mul_start)
        wait_q <= 1'b1;
      else if (call_fire)
        wait_q <= 1'b0;
    end
  end

  assign busy      = (step_q != STP_IDLE);
  assign mul_start = busy && !wait_q;
  assign done      = done_q;
endmodule

// File: rtl/modexp_sequencer_chk.sv
module modexp_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       mul_start,
  input logic [1:0] mul_sel_a,
  input logic [1:0] mul_sel_b,
  input logic       mul_dest,
  input logic       mul_done
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)
      outstanding <= 1'b0;
    else if (mul_start)
      outstanding <= 1'b1;
    else if (mul_done)
      outstanding <= 1'b0;
  end

  p_idle_reset_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !mul_start));

  p_entry_call_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mul_start && mul_sel_a == 2'd3 && mul_sel_b == 2'd2 && !mul_dest && $past(start)));

  p_p_written_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_start && mul_dest) |-> (mul_sel_a == 2'd3 && mul_sel_b == 2'd1));

  p_done_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mul_done) && $past(outstanding) && !busy));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  p_one_call_r6: assert property (@(posedge clk) disable iff (!rst_n) mul_start |-> !outstanding);

  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) mul_start |=> !mul_start);

  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done && !outstanding && !busy) |=> (!done && !mul_start));

  p_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done && outstanding && busy) |=> (mul_start ^ done));
endmodule

bind modexp_sequencer modexp_sequencer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mul_start(mul_start),
  .mul_sel_a(mul_sel_a),
  .mul_sel_b(mul_sel_b),
  .mul_dest (mul_dest),
  .mul_done (mul_done)
);

// File: tb/modexp_sequencer_test.sv
module modexp_sequencer_test;
  localparam int EXP_W = 32;
  localparam int LEN_W = $clog2(EXP_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [EXP_W-1:0] exp_bits = '0;
  logic [LEN_W-1:0] exp_len = '0;
  logic busy, done, mul_start, mul_dest;
  logic [1:0] mul_sel_a, mul_sel_b;
  logic model_done = 1'b0;
  logic stray = 1'b0;
  logic mul_done;

  assign mul_done = model_done | stray;

  always #2 clk = ~clk;

  modexp_sequencer #(.EXP_W(EXP_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_bits(exp_bits), .exp_len(exp_len),
    .busy(busy), .done(done), .mul_start(mul_start), .mul_sel_a(mul_sel_a),
    .mul_sel_b(mul_sel_b), .mul_dest(mul_dest), .mul_done(mul_done)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Montgomery product for one 17-bit digit, computed bit-serially.
  function automatic longint mont(longint a, longint b, longint m);
    longint t = 0;
    for (int i = 0; i < 17; i++) begin
      if (a[i]) t += b;
      if (t[0]) t += m;
      t = t >>> 1;
    end
    if (t >= m) t -= m;
    return t;
  endfunction

  function automatic longint plain_pow(longint p, longint e, int len, longint m);
    longint r = 1 % m;
    for (int i = len - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if (e[i]) r = (r * p) % m;
    end
    return r;
  endfunction

  // Multiplier model
  longint reg_c, reg_p, msg, modulus, r2;
  int     calls;
  int     lat;
  bit     pend = 0;
  bit     prev_start = 0;
  bit     prev_mdone = 0;
  logic [1:0] la, lb;
  logic       ld;
  logic [4:0] first_code, second_code, last_code;

  function automatic longint opnd(logic [1:0] code);
    case (code)
      2'd0: return reg_c;
      2'd1: return reg_p;
      2'd2: return 1;
      default: return r2;
    endcase
  endfunction

  always @(negedge clk) begin
    if (prev_mdone && rst_n)  // R11: next call or done right after completion
      check(mul_start || done, "R11", longint'(mul_start), 1);
    prev_mdone = 1'b0;
    model_done = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        longint res;
        res = mont(opnd(la), opnd(lb), modulus);
        if (ld) reg_p = res; else reg_c = res;
        model_done = 1'b1;
        prev_mdone = 1'b1;
        pend = 0;
      end else lat--;
    end
    if (mul_start && rst_n) begin
      if (prev_start) check(0, "R7", 1, 0);
      if (pend) check(0, "R6", 1, 0);
      pend = 1;
      la = mul_sel_a; lb = mul_sel_b; ld = mul_dest;
      lat = calls % 3;
      if (calls == 0) first_code = {la, lb, ld};
      if (calls == 1) second_code = {la, lb, ld};
      last_code = {la, lb, ld};
      calls++;
    end
    prev_start = mul_start;
  end

  // Scoreboard
  typedef struct { longint result; int ncalls; string tag; } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) check(0, "R8", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(reg_c == it.result, {"R3 ", it.tag}, reg_c, it.result);
        check(calls == it.ncalls, {"R5 ", it.tag}, calls, it.ncalls);
        check(first_code == {2'd3, 2'd2, 1'b0}, "R2 first call", first_code, {2'd3, 2'd2, 1'b0});
        check(second_code == {2'd3, 2'd1, 1'b1}, "R2 second call", second_code, {2'd3, 2'd1, 1'b1});
        check(last_code == {2'd0, 2'd2, 1'b0}, "R4 last call", last_code, {2'd0, 2'd2, 1'b0});
        check(!busy, "R4 busy at done", busy, 0);
      end
    end
  end

  task automatic run_case(input longint p, input longint e, input int len, input longint m,
                          input bit hold, input bit scramble, input string tag);
    item_t it;
    int ones = 0;
    for (int i = 0; i < len; i++) if (e[i]) ones++;
    it.result = plain_pow(p, e, len, m);
    it.ncalls = 3 + len + ones;
    it.tag = tag;
    sb.push_back(it);
    msg = p; modulus = m; r2 = (longint'(1) << 34) % m;
    reg_p = p; reg_c = 0; calls = 0;
    @(negedge clk);
    exp_bits = EXP_W'(e);
    exp_len = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    if (scramble) begin  // R8: inputs change after acceptance
      exp_bits = ~exp_bits;
      exp_len = LEN_W'(3);
    end
    while (!done) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !mul_start, {"R8 no restart ", tag}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mul_start, "R1", {busy, done, mul_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mul_start, "R1 after release", {busy, done, mul_start}, 0);

    // R10: stray completion while idle
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && !mul_start, "R10", {busy, done, mul_start}, 0);

    run_case(5, 'b1011, 4, 9973, 0, 0, "basic");
    run_case(1234, 0, 8, 9973, 0, 0, "R9 zero exponent");
    run_case(4321, 'hFF, 0, 12345, 0, 0, "R9 zero length");
    run_case(777, 'hFFFF_FFFF, 32, 12345, 1, 0, "R8 held start all ones");
    run_case(3000, 'h8000_0001, 32, 16383, 0, 1, "R8 scrambled inputs");
    run_case(0, 'h15, 5, 9973, 0, 0, "zero message");
    run_case(1234, 65537, 17, 16383, 1, 1, "R3 long scan");
    run_case(2, 1, 1, 3, 0, 0, "R3 single bit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule